// File: doc/BRIEF.md
# Capture/Compare Timer with Per-Register Mode Select

This block holds a 16-bit free-running up-counter and a small bank of general registers. Software sets each register at run time to one of two jobs. As a compare register, it watches the counter and updates its own output pin on a match. As a capture register, it copies the counter when a chosen edge appears on its input pin, or when a strobe arrives from another timer. Every event sets a sticky flag. Per-flag enables combine those flags onto one interrupt line.

A host configures and reads the block through a flat register port. The address is split into a two-bit region selector above an index field. Region 0 holds the global registers, region 1 holds one configuration word per register, and region 2 holds the register values. With the default bank of four, the configuration words sit at 4+i and the values at 8+i. Writes take effect on the clock edge on which `bus_we` is high. Reads are combinational from the registered state.

Top module: `capcomp_timer`

## Requirements
- R1: The counter (address 0, read/write) increments by one on every clock edge while the run bit (bit 0 of address 1) is set, and holds its value while that bit is clear. A host write to address 0 loads the counter and takes priority over counting.
- R2: When the counter is at 0xFFFF and running, the next edge gives 0x0000. On that same edge the overflow flag, bit N of the status word at address 2 (N is the bank size, default 4), is set.
- R3: Configuration bit 0 selects compare when 0 and capture when 1. In compare mode, if the counter equals the register while the run bit is set, then on the next edge the register's output pin follows the action code in config bits 2:1 (00 keep, 01 drive low, 10 drive high, 11 invert), and status bit i is set.
- R4: In capture mode with config bit 5 clear, each pin passes through a two-flop synchronizer. An edge chosen by config bits 4:3 (00 none, 01 rising, 10 falling, 11 both) copies the counter into the register on the third clock edge after the pin changes, and sets status bit i. The copied value is the count as it stood two edges after the change.
- R5: In capture mode with config bit 5 set, a high `ext_trig` at a clock edge copies the counter into the register on that edge and sets status bit i. Pin edges are then ignored.
- R6: A register in compare mode is never loaded by pin edges or by `ext_trig`. A register in capture mode never changes its output pin.
- R7: Writing the status word clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. A new event in the same cycle as a clear leaves its flag set.
- R8: `irq` is high exactly when some status flag is set whose bit in the enable word (address 3, same layout as status) is also set.
- R9: If a capture and a host write to the same register fall on the same edge, the register takes the captured count.
- R10: After reset the counter, the register values, the configuration words, the status and enable words, the run bit, all output pins and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW (4) | Register address: region in the top two bits, index below |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_pin | input | NREG (4) | Asynchronous capture inputs, one per register |
| ext_trig | input | 1 | Synchronous capture strobe from another timer |
| cmp_out | output | NREG (4) | Compare outputs, one per register |
| irq | output | 1 | Combined masked interrupt request |

## Verification
Compare is tried with random match values and all four action codes, starting from a known pin level. This separates keep, low, high and invert, and it pins the output change to the edge after the match. Capture is tried with each edge selector against both rising and falling pin changes, so a wrong edge decoder or an inverted polarity shows up as a captured value where the old one should remain. Running-counter cases for both the pin path and the trigger path fix the synchronizer latency and the trigger's zero latency. Directed cases set up a collision, where one event lands on the same edge as a host write to a register or to the status word, to show which one wins.

// File: rtl/capcomp_pkg.sv
package capcomp_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    EDG_NONE = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_e;

  // bit 5 trigger source, bits 4:3 edge, bits 2:1 action, bit 0 capture mode
  typedef struct packed {
    logic  trig_sel;
    edge_e edg;
    act_e  act;
    logic  cap_mode;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  localparam logic [1:0] REG_GLOBAL = 2'b00;
  localparam logic [1:0] REG_CFG    = 2'b01;
  localparam logic [1:0] REG_GR     = 2'b10;

  // global index inside REG_GLOBAL
  localparam int G_COUNT  = 0;
  localparam int G_CTRL   = 1;
  localparam int G_STATUS = 2;
  localparam int G_IEN    = 3;

  function automatic logic edge_hit(edge_e sel, logic cur, logic prev);
    logic hit;
    case (sel)
      EDG_RISE: hit = cur & ~prev;
      EDG_FALL: hit = ~cur & prev;
      EDG_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic next_out(act_e a, logic cur);
    logic nxt;
    case (a)
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_FLIP: nxt = ~cur;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  // a host load overrides the wrap of the same edge
  assign wrap = run && !wr_en && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_val;
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import capcomp_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chan_cfg_t    cfg,
  input  logic [W-1:0] cnt,
  input  logic         run,
  input  logic         pin,
  input  logic         ext_trig,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] gr,
  output logic         out_pin,
  output logic         cap_evt,
  output logic         match_evt
);
  // shr[SYNC-1] is the synchronized level, shr[SYNC] the previous one
  logic [SYNC:0] shr;
  logic          pin_cur;
  logic          pin_prev;
  logic          pin_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC-1:0], pin};
  end

  assign pin_cur   = shr[SYNC-1];
  assign pin_prev  = shr[SYNC];
  assign pin_edge  = edge_hit(cfg.edg, pin_cur, pin_prev);
  assign cap_evt   = cfg.cap_mode && (cfg.trig_sel ? ext_trig : pin_edge);
  assign match_evt = !cfg.cap_mode && run && (cnt == gr);

  // capture beats a host write on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr <= '0;
    else if (cap_evt) gr <= cnt;
    else if (wr_en)   gr <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_pin <= 1'b0;
    else if (match_evt) out_pin <= next_out(cfg.act, out_pin);
  end
endmodule

// File: rtl/cc_flags.sv
module cc_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_mask,
  input  logic          en_wr,
  input  logic [NF-1:0] en_val,
  output logic [NF-1:0] status,
  output logic [NF-1:0] enable,
  output logic          irq
);
  logic [NF-1:0] clr_now;

  assign clr_now = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_now) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_wr) enable <= en_val;
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/capcomp_timer.sv
module capcomp_timer
  import capcomp_pkg::*;
#(
  parameter int NREG = 4,
  parameter int W    = 16,
  parameter int SYNC = 2,
  localparam int IW  = (NREG <= 4) ? 2 : $clog2(NREG),
  localparam int AW  = IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [NREG-1:0] cap_pin,
  input  logic            ext_trig,
  output logic [NREG-1:0] cmp_out,
  output logic            irq
);
  localparam int NF = NREG + 1;

  logic [1:0]               region;
  logic [IW-1:0]            idx;
  logic                     cnt_wr;
  logic                     ctrl_wr;
  logic                     stat_wr;
  logic                     ien_wr;
  logic [NREG-1:0]          cfg_wr;
  logic [NREG-1:0]          gr_wr;
  logic                     run_q;
  logic [W-1:0]             cnt_q;
  logic                     wrap_evt;
  logic [NREG-1:0]          cap_evt;
  logic [NREG-1:0]          match_evt;
  logic [NREG-1:0][W-1:0]   gr_all;
  logic [NF-1:0]            status_q;
  logic [NF-1:0]            enable_q;
  chan_cfg_t                cfg_q [NREG];

  assign region = bus_addr[AW-1:IW];
  assign idx    = bus_addr[IW-1:0];

  assign cnt_wr  = bus_we && (region == REG_GLOBAL) && (idx == IW'(G_COUNT));
  assign ctrl_wr = bus_we && (region == REG_GLOBAL) && (idx == IW'(G_CTRL));
  assign stat_wr = bus_we && (region == REG_GLOBAL) && (idx == IW'(G_STATUS));
  assign ien_wr  = bus_we && (region == REG_GLOBAL) && (idx == IW'(G_IEN));

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cfg_wr[i] = bus_we && (region == REG_CFG) && (idx == IW'(i));
      gr_wr[i]  = bus_we && (region == REG_GR)  && (idx == IW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ctrl_wr) run_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (cfg_wr[i]) cfg_q[i] <= chan_cfg_t'(bus_wdata[CFG_W-1:0]);
    end
  end

  cc_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .wr_en  (cnt_wr),
    .wr_val (bus_wdata),
    .cnt    (cnt_q),
    .wrap   (wrap_evt)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_chan
    cc_channel #(.W(W), .SYNC(SYNC)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg_q[g]),
      .cnt       (cnt_q),
      .run       (run_q),
      .pin       (cap_pin[g]),
      .ext_trig  (ext_trig),
      .wr_en     (gr_wr[g]),
      .wr_val    (bus_wdata),
      .gr        (gr_all[g]),
      .out_pin   (cmp_out[g]),
      .cap_evt   (cap_evt[g]),
      .match_evt (match_evt[g])
    );
  end

  cc_flags #(.NF(NF)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  ({wrap_evt, cap_evt | match_evt}),
    .clr_wr   (stat_wr),
    .clr_mask (bus_wdata[NF-1:0]),
    .en_wr    (ien_wr),
    .en_val   (bus_wdata[NF-1:0]),
    .status   (status_q),
    .enable   (enable_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (region)
      REG_GLOBAL: begin
        if (idx == IW'(G_COUNT))       bus_rdata = cnt_q;
        else if (idx == IW'(G_CTRL))   bus_rdata[0] = run_q;
        else if (idx == IW'(G_STATUS)) bus_rdata[NF-1:0] = status_q;
        else if (idx == IW'(G_IEN))    bus_rdata[NF-1:0] = enable_q;
      end
      REG_CFG: begin
        for (int i = 0; i < NREG; i++)
          if (idx == IW'(i)) bus_rdata[CFG_W-1:0] = cfg_q[i];
      end
      REG_GR: begin
        for (int i = 0; i < NREG; i++)
          if (idx == IW'(i)) bus_rdata = gr_all[i];
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/capcomp_timer_check.sv
module capcomp_timer_check #(
  parameter int NREG = 4,
  parameter int W    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   cnt_wr,
  input logic [W-1:0]           cnt,
  input logic                   wrap_evt,
  input logic [NREG-1:0]        cap_evt,
  input logic [NREG-1:0]        match_evt,
  input logic [NREG-1:0]        gr_wr,
  input logic [NREG-1:0][W-1:0] gr_all,
  input logic [NREG-1:0]        cmp_out,
  input logic [NREG:0]          status,
  input logic [NREG:0]          enable,
  input logic                   irq
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (status[NREG] && (cnt == '0)));

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !match_evt[g] |=> $stable(cmp_out[g]));

    p_gr_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_evt[g] && !gr_wr[g]) |=> $stable(gr_all[g]));

    p_cap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[g] |=> (gr_all[g] == $past(cnt)));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt[g] || match_evt[g]) |=> status[g]);
  end
endmodule

bind capcomp_timer capcomp_timer_check #(.NREG(NREG), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .cnt_wr    (cnt_wr),
  .cnt       (cnt_q),
  .wrap_evt  (wrap_evt),
  .cap_evt   (cap_evt),
  .match_evt (match_evt),
  .gr_wr     (gr_wr),
  .gr_all    (gr_all),
  .cmp_out   (cmp_out),
  .status    (status_q),
  .enable    (enable_q),
  .irq       (irq)
);

// File: tb/sim_capcomp_timer.sv
module sim_capcomp_timer;
  localparam logic [3:0] A_CNT = 4'd0, A_CTRL = 4'd1, A_STAT = 4'd2, A_IEN = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_pin = '0;
  logic        ext_trig = 1'b0;
  logic [3:0]  cmp_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0] m_out = '0;

  always #4 clk = ~clk;

  capcomp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .ext_trig(ext_trig), .cmp_out(cmp_out), .irq(irq)
  );

  function automatic logic [15:0] mk_cfg(logic trig, logic [1:0] edg, logic [1:0] act, logic cap);
    return {10'd0, trig, edg, act, cap};
  endfunction

  function automatic logic exp_pin(logic [1:0] act, logic cur);
    if (act == 2'b01) return 1'b0;
    if (act == 2'b10) return 1'b1;
    if (act == 2'b11) return !cur;
    return cur;
  endfunction

  function automatic logic exp_hit(logic [1:0] sel, logic oldv, logic newv);
    if (oldv == newv) return 1'b0;
    if (sel == 2'b11) return 1'b1;
    if (sel == 2'b01) return newv;
    if (sel == 2'b10) return !newv;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0, x, q, g;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(A_CNT, v);  chk("R10 count", v, 16'h0);
    rd(A_STAT, v); chk("R10 status", v, 16'h0);
    rd(4'd8, v);   chk("R10 gr0", v, 16'h0);
    rd(4'd4, v);   chk("R10 cfg0", v, 16'h0);
    chk("R10 outputs", {12'd0, cmp_out}, 16'h0);
    chk("R10 irq", {15'd0, irq}, 16'h0);

    // R1 hold and count
    wr(A_CNT, 16'h0100);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R1 hold while stopped", v, 16'h0100);
    wr(A_CTRL, 16'h1);
    for (int k = 0; k < 3; k++) begin
      int n;
      n = 1 + $urandom % 20;
      rd(A_CNT, c0);
      repeat (n) @(negedge clk);
      rd(A_CNT, v); chk("R1 increment", v, c0 + 16'(n));
    end

    // R2 wrap and overflow flag
    wr(A_CTRL, 16'h0);
    wr(A_CNT, 16'hFFFD);
    wr(A_STAT, 16'hFFFF);
    wr(A_CTRL, 16'h1);
    rd(A_STAT, v); chk("R2 no overflow early", v & 16'h10, 16'h0);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R2 at top", v, 16'hFFFF);
    @(negedge clk);
    rd(A_CNT, v); chk("R2 wrapped", v, 16'h0000);
    rd(A_STAT, v); chk("R2 overflow flag", v & 16'h10, 16'h10);
    wr(A_CTRL, 16'h0);

    // R3 compare actions
    for (int i = 0; i < 4; i++) wr(4'(4 + i), mk_cfg(0, 2'b00, 2'b00, 0));
    for (int k = 0; k < 12; k++) begin
      int i;
      logic [1:0] act;
      i = $urandom % 4;
      act = 2'($urandom);
      g = 16'(16 + $urandom % 16'hFF00);
      wr(A_CTRL, 16'h0);
      wr(4'(4 + i), mk_cfg(0, 2'b00, act, 0));
      wr(4'(8 + i), g);
      wr(A_CNT, g - 16'd3);
      wr(A_STAT, 16'hFFFF);
      wr(A_CTRL, 16'h1);
      repeat (3) @(negedge clk);
      chk("R3 output before match", {15'd0, cmp_out[i]}, {15'd0, m_out[i]});
      rd(A_STAT, v); chk("R3 flag before match", (v >> i) & 16'h1, 16'h0);
      @(negedge clk);
      m_out[i] = exp_pin(act, m_out[i]);
      chk("R3 output after match", {15'd0, cmp_out[i]}, {15'd0, m_out[i]});
      rd(A_STAT, v); chk("R3 flag after match", (v >> i) & 16'h1, 16'h1);
      wr(A_CTRL, 16'h0);
      wr(4'(4 + i), mk_cfg(0, 2'b00, 2'b00, 0));
    end

    // R4 edge-selected capture with stopped counter
    for (int k = 0; k < 16; k++) begin
      int i;
      logic [1:0] sel;
      logic hit, nv;
      i = $urandom % 4;
      sel = 2'($urandom);
      x = 16'($urandom);
      q = 16'($urandom);
      wr(A_CNT, x);
      wr(4'(4 + i), mk_cfg(0, sel, 2'b11, 1));
      wr(4'(8 + i), q);
      wr(A_STAT, 16'hFFFF);
      @(negedge clk);
      nv = !cap_pin[i];
      hit = exp_hit(sel, cap_pin[i], nv);
      cap_pin[i] = nv;
      repeat (5) @(negedge clk);
      rd(4'(8 + i), v); chk("R4 captured value", v, hit ? x : q);
      rd(A_STAT, v); chk("R4 capture flag", (v >> i) & 16'h1, {15'd0, hit});
      chk("R6 capture mode output held", {12'd0, cmp_out}, {12'd0, m_out});
    end

    // R4 latency with running counter
    wr(4'd4, mk_cfg(0, 2'b01, 2'b00, 1));
    if (cap_pin[0]) begin
      @(negedge clk); cap_pin[0] = 1'b0; repeat (5) @(negedge clk);
    end
    wr(A_CTRL, 16'h1);
    @(negedge clk);
    rd(A_CNT, c0);
    cap_pin[0] = 1'b1;
    repeat (6) @(negedge clk);
    wr(A_CTRL, 16'h0);
    rd(4'd8, v); chk("R4 synchronizer latency", v, c0 + 16'd2);

    // R5 trigger source, pin ignored
    x = 16'($urandom); q = 16'($urandom);
    wr(A_CNT, x);
    wr(4'd5, mk_cfg(1, 2'b11, 2'b00, 1));
    wr(4'd9, q);
    wr(A_STAT, 16'hFFFF);
    @(negedge clk); cap_pin[1] = !cap_pin[1];
    repeat (5) @(negedge clk);
    rd(4'd9, v); chk("R5 pin ignored under trigger", v, q);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    rd(4'd9, v); chk("R5 trigger capture", v, x);
    rd(A_STAT, v); chk("R5 trigger flag", v & 16'h2, 16'h2);
    wr(A_CTRL, 16'h1);
    @(negedge clk);
    rd(A_CNT, c0);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    wr(A_CTRL, 16'h0);
    rd(4'd9, v); chk("R5 trigger zero latency", v, c0);

    // R6 compare mode ignores pin and trigger
    q = 16'h5A5A;
    wr(A_CNT, 16'h1234);
    wr(4'd6, mk_cfg(0, 2'b11, 2'b00, 0));
    wr(4'd10, q);
    @(negedge clk); cap_pin[2] = !cap_pin[2];
    repeat (5) @(negedge clk);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    rd(4'd10, v); chk("R6 compare register untouched", v, q);

    // R7 write-one-to-clear
    wr(4'd4, mk_cfg(1, 2'b00, 2'b00, 1));
    wr(4'd5, mk_cfg(1, 2'b00, 2'b00, 1));
    wr(4'd7, mk_cfg(0, 2'b00, 2'b00, 0));
    wr(A_STAT, 16'hFFFF);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    rd(A_STAT, v); chk("R7 flags set", v, 16'h3);
    wr(A_STAT, 16'h1);
    rd(A_STAT, v); chk("R7 clear one bit", v, 16'h2);
    wr(A_STAT, 16'h0);
    rd(A_STAT, v); chk("R7 zero write keeps", v, 16'h2);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 16'h3; bus_we = 1'b1; ext_trig = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ext_trig = 1'b0;
    rd(A_STAT, v); chk("R7 set beats clear", v, 16'h3);

    // R8 interrupt masking, status is 0x03
    for (int k = 0; k < 6; k++) begin
      logic [4:0] m;
      m = (k == 0) ? 5'h0 : (k == 1) ? 5'h10 : 5'($urandom);
      wr(A_IEN, {11'd0, m});
      chk("R8 irq", {15'd0, irq}, {15'd0, |(m & 5'h03)});
    end

    // R9 capture beats host write
    x = 16'hC3A5;
    wr(A_CNT, x);
    @(negedge clk);
    bus_addr = 4'd8; bus_wdata = 16'h0F0F; bus_we = 1'b1; ext_trig = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ext_trig = 1'b0;
    rd(4'd8, v); chk("R9 capture wins", v, x);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule